// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Three Page Sizes

This block caches virtual-to-physical page translations in a small tag array that is searched as a whole on every lookup. The virtual page number and the address-space identifier of a request are compared against all valid entries at once. The block then returns a hit flag, the physical address and the attribute bits of the winning entry. Each entry maps one of three page sizes, 4KB, 2MB or 1GB. For the larger sizes the low bits of the stored page number are excluded from the compare, so one array serves all three sizes in a single search.

An external page walker writes new translations through the fill port. The block chooses the slot: the lowest free slot if there is one, otherwise the slot under a round-robin pointer. Software or a context switch removes translations through the flush-all control or the flush-by-identifier control. Entries marked global are shared by every address space. They ignore the identifier compare and survive a flush by identifier. When several entries match, the largest page wins, and the lowest slot number breaks ties.

Top module: `tlb_cam`

## Requirements
- R1: A lookup presented with `lk_valid` high at a rising edge produces its result on `lk_hit`, `lk_pa`, `lk_attr` and `lk_size` after that edge. On a miss, `lk_pa`, `lk_attr` and `lk_size` read zero. In cycles without a lookup, all four outputs keep their values.
- R2: An entry matches only if every compared page-number bit equals the key. A single differing bit, at either end of the 36-bit key, rejects the entry.
- R3: Size code 0 is a 4KB page and compares all 36 page-number bits. Code 1 is a 2MB page and ignores the low 9 bits. Code 2 is a 1GB page and ignores the low 18 bits. Code 3 behaves like code 0. `lk_size` reports the code of the winning entry.
- R4: A non-global entry matches only when its stored identifier equals `lk_asid`.
- R5: A global entry matches on the page number alone, whatever `lk_asid` carries.
- R6: When several entries match, the entry with the largest size code wins. Among matches of the same size, the lowest-numbered entry wins.
- R7: The physical address is formed as follows. Bits at and above the page offset come from the entry's frame number. The offset bits come from `lk_va`. The offset is 12, 21 or 30 bits for size codes 0, 1 and 2.
- R8: While an invalid slot exists, a fill writes the lowest-numbered invalid slot. The number of valid entries grows by at most one per cycle.
- R9: When all slots are valid, a fill replaces the slot named by a pointer. The pointer is 0 on reset and advances by one on every clock cycle, modulo the entry count.
- R10: A lookup in the same cycle as a fill sees the array as it was before the fill. The new entry is visible from the next cycle.
- R11: `flush_all` invalidates every entry. A lookup in the same cycle still sees the old contents. A fill in the same cycle is dropped.
- R12: `flush_asid_en` invalidates, in one cycle, exactly the non-global entries whose identifier equals `flush_asid`. A fill in the same cycle is dropped.
- R13: While `rst_n` is low, every entry is invalid and `lk_hit`, `lk_pa`, `lk_attr` and `lk_size` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 48 | Virtual address to translate |
| lk_asid | input | 16 | Address-space identifier of the lookup |
| lk_hit | output | 1 | A valid entry matched |
| lk_pa | output | 40 | Translated physical address |
| lk_attr | output | 8 | Attribute bits of the winning entry |
| lk_size | output | 2 | Size code of the winning entry |
| fill_valid | input | 1 | Write a new translation |
| fill_vpn | input | 36 | Virtual page number of the new entry |
| fill_asid | input | 16 | Identifier of the new entry |
| fill_global | input | 1 | New entry is shared by all address spaces |
| fill_size | input | 2 | Size code of the new entry |
| fill_pfn | input | 28 | Physical frame number of the new entry |
| fill_attr | input | 8 | Attribute bits of the new entry |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_en | input | 1 | Invalidate non-global entries of one identifier |
| flush_asid | input | 16 | Identifier to invalidate |

## Verification
A lookup can share a cycle with a fill, and also with either flush. The bench provokes both cases by driving a fill or a flush together with a lookup of the very page being written or removed. A correct design answers that lookup from the old array contents and changes its answer only on the following lookup. A fill that coincides with a flush must leave no trace in later lookups. A behavioural model that applies each cycle's search before its writes supplies the expected result of every cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    PG_SMALL = 2'd0,
    PG_MID   = 2'd1,
    PG_BIG   = 2'd2,
    PG_RSVD  = 2'd3
  } pg_e;
endpackage

// File: rtl/tlb_match_array.sv
module tlb_match_array #(
  parameter int ENTRIES  = 64,
  parameter int VPN_W    = 36,
  parameter int ASID_W   = 16,
  parameter int LVL_BITS = 9
) (
  input  logic [ENTRIES-1:0]             valid_q,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_q,
  input  logic [ENTRIES-1:0]             glob_q,
  input  logic [ENTRIES-1:0][1:0]        size_q,
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [ASID_W-1:0]              key_asid,
  output logic [ENTRIES-1:0]             hit_small,
  output logic [ENTRIES-1:0]             hit_mid,
  output logic [ENTRIES-1:0]             hit_big
);
  import tlb_pkg::*;

  localparam logic [VPN_W-1:0] CARE_ALL = {VPN_W{1'b1}};
  localparam logic [VPN_W-1:0] CARE_MID = CARE_ALL << LVL_BITS;
  localparam logic [VPN_W-1:0] CARE_BIG = CARE_ALL << (2 * LVL_BITS);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    logic [VPN_W-1:0] care;
    logic             tag_eq;
    logic             asid_ok;
    logic             row_hit;

    always_comb begin
      case (pg_e'(size_q[g]))
        PG_MID:  care = CARE_MID;
        PG_BIG:  care = CARE_BIG;
        default: care = CARE_ALL;
      endcase
      tag_eq  = ((vpn_q[g] ^ key_vpn) & care) == '0;
      asid_ok = glob_q[g] || (asid_q[g] == key_asid);
      row_hit = valid_q[g] && tag_eq && asid_ok;
    end

    assign hit_big[g]   = row_hit && (pg_e'(size_q[g]) == PG_BIG);
    assign hit_mid[g]   = row_hit && (pg_e'(size_q[g]) == PG_MID);
    assign hit_small[g] = row_hit && (pg_e'(size_q[g]) != PG_BIG)
                                  && (pg_e'(size_q[g]) != PG_MID);
  end
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hit_small,
  input  logic [ENTRIES-1:0] hit_mid,
  input  logic [ENTRIES-1:0] hit_big,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx
);
  logic [ENTRIES-1:0] pick;

  always_comb begin
    if (|hit_big)      pick = hit_big;
    else if (|hit_mid) pick = hit_mid;
    else               pick = hit_small;
    any_hit = |pick;
    win_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (pick[i]) win_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_q,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] free_idx;
  logic             have_free;

  always_comb begin
    ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_comb begin
    have_free = ~&valid_q;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
    victim = have_free ? free_idx : ptr_q;
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES  = 64,
  parameter int VA_W     = 48,
  parameter int PA_W     = 40,
  parameter int OFF_W    = 12,
  parameter int ASID_W   = 16,
  parameter int ATTR_W   = 8,
  parameter int LVL_BITS = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [VA_W-1:0]          lk_va,
  input  logic [ASID_W-1:0]        lk_asid,
  output logic                     lk_hit,
  output logic [PA_W-1:0]          lk_pa,
  output logic [ATTR_W-1:0]        lk_attr,
  output logic [1:0]               lk_size,
  input  logic                     fill_valid,
  input  logic [VA_W-OFF_W-1:0]    fill_vpn,
  input  logic [ASID_W-1:0]        fill_asid,
  input  logic                     fill_global,
  input  logic [1:0]               fill_size,
  input  logic [PA_W-OFF_W-1:0]    fill_pfn,
  input  logic [ATTR_W-1:0]        fill_attr,
  input  logic                     flush_all,
  input  logic                     flush_asid_en,
  input  logic [ASID_W-1:0]        flush_asid
);
  import tlb_pkg::*;

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  // entry storage
  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [ENTRIES-1:0]             fill_we;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0]             glob_q;
  logic [ENTRIES-1:0][1:0]        size_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0][ATTR_W-1:0] attr_q;

  logic [ENTRIES-1:0] hit_small, hit_mid, hit_big;
  logic               any_hit;
  logic [IDX_W-1:0]   win_idx;
  logic [IDX_W-1:0]   victim;

  tlb_match_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .LVL_BITS(LVL_BITS)
  ) u_match (
    .valid_q  (valid_q),
    .vpn_q    (vpn_q),
    .asid_q   (asid_q),
    .glob_q   (glob_q),
    .size_q   (size_q),
    .key_vpn  (lk_va[VA_W-1:OFF_W]),
    .key_asid (lk_asid),
    .hit_small(hit_small),
    .hit_mid  (hit_mid),
    .hit_big  (hit_big)
  );

  tlb_prio #(.ENTRIES(ENTRIES)) u_prio (
    .hit_small(hit_small),
    .hit_mid  (hit_mid),
    .hit_big  (hit_big),
    .any_hit  (any_hit),
    .win_idx  (win_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid_q(valid_q),
    .victim (victim)
  );

  // valid bits: flushes first, a fill only when no flush is active
  always_comb begin
    valid_d = valid_q;
    fill_we = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (flush_all) begin
        valid_d[i] = 1'b0;
      end else if (flush_asid_en && !glob_q[i] && (asid_q[i] == flush_asid)) begin
        valid_d[i] = 1'b0;
      end
    end
    if (fill_valid && !flush_all && !flush_asid_en) begin
      fill_we[victim] = 1'b1;
      valid_d[victim] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (fill_we[g]) begin
        vpn_q[g]  <= fill_vpn;
        asid_q[g] <= fill_asid;
        glob_q[g] <= fill_global;
        size_q[g] <= fill_size;
        pfn_q[g]  <= fill_pfn;
        attr_q[g] <= fill_attr;
      end
    end
  end

  // result formation
  logic [PFN_W-1:0]  sel_pfn;
  logic [1:0]        sel_size;
  logic [5:0]        off_bits;
  logic [PA_W-1:0]   off_mask;
  logic [PA_W-1:0]   pa_calc;
  logic              hit_d;
  logic [PA_W-1:0]   pa_d;
  logic [ATTR_W-1:0] attr_d;
  logic [1:0]        size_d;

  always_comb begin
    sel_pfn  = pfn_q[win_idx];
    sel_size = size_q[win_idx];
    case (pg_e'(sel_size))
      PG_MID:  off_bits = 6'(OFF_W + LVL_BITS);
      PG_BIG:  off_bits = 6'(OFF_W + 2 * LVL_BITS);
      default: off_bits = 6'(OFF_W);
    endcase
    off_mask = (PA_W'(1) << off_bits) - PA_W'(1);
    pa_calc  = ({sel_pfn, {OFF_W{1'b0}}} & ~off_mask) | (lk_va[PA_W-1:0] & off_mask);
  end

  always_comb begin
    hit_d  = lk_hit;
    pa_d   = lk_pa;
    attr_d = lk_attr;
    size_d = lk_size;
    if (lk_valid) begin
      hit_d  = any_hit;
      pa_d   = any_hit ? pa_calc : '0;
      attr_d = any_hit ? attr_q[win_idx] : '0;
      size_d = any_hit ? sel_size : 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit  <= 1'b0;
      lk_pa   <= '0;
      lk_attr <= '0;
      lk_size <= 2'd0;
    end else begin
      lk_hit  <= hit_d;
      lk_pa   <= pa_d;
      lk_attr <= attr_d;
      lk_size <= size_d;
    end
  end
endmodule

// File: rtl/tlb_cam_chk.sv
module tlb_cam_chk #(
  parameter int ENTRIES = 64,
  parameter int PA_W    = 40,
  parameter int ATTR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic [PA_W-1:0]    lk_pa,
  input logic [ATTR_W-1:0]  lk_attr,
  input logic [1:0]         lk_size,
  input logic               flush_all,
  input logic [ENTRIES-1:0] valid_q
);
  // R1
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable(lk_hit) && $stable(lk_pa) && $stable(lk_attr) && $stable(lk_size));

  // R1
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == '0) && (lk_attr == '0) && (lk_size == 2'd0));

  // R8
  grow_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q) <= $countones($past(valid_q)) + 1);

  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> valid_q == '0);

  // R11
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all ##1 lk_valid |=> !lk_hit);
endmodule

bind tlb_cam tlb_cam_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W), .ATTR_W(ATTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_valid (lk_valid),
  .lk_hit   (lk_hit),
  .lk_pa    (lk_pa),
  .lk_attr  (lk_attr),
  .lk_size  (lk_size),
  .flush_all(flush_all),
  .valid_q  (valid_q)
);

// File: tb/sim_tlb_cam.sv
module sim_tlb_cam;
  localparam int CLK_PERIOD = 10;
  localparam int ENT = 64;

  logic        clk, rst_n;
  logic        lk_valid;
  logic [47:0] lk_va;
  logic [15:0] lk_asid;
  logic        lk_hit;
  logic [39:0] lk_pa;
  logic [7:0]  lk_attr;
  logic [1:0]  lk_size;
  logic        fill_valid;
  logic [35:0] fill_vpn;
  logic [15:0] fill_asid;
  logic        fill_global;
  logic [1:0]  fill_size;
  logic [27:0] fill_pfn;
  logic [7:0]  fill_attr;
  logic        flush_all, flush_asid_en;
  logic [15:0] flush_asid;

  tlb_cam u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference model
  bit          m_v[ENT];
  logic [35:0] m_vpn[ENT];
  logic [15:0] m_asid[ENT];
  bit          m_g[ENT];
  logic [1:0]  m_sz[ENT];
  logic [27:0] m_pfn[ENT];
  logic [7:0]  m_attr[ENT];
  int          m_ptr = 0;
  logic        e_hit = 0;
  logic [39:0] e_pa = 0;
  logic [7:0]  e_attr = 0;
  logic [1:0]  e_sz = 0;

  task automatic idle_inputs();
    lk_valid = 0; lk_va = '0; lk_asid = '0;
    fill_valid = 0; fill_vpn = '0; fill_asid = '0; fill_global = 0;
    fill_size = 0; fill_pfn = '0; fill_attr = '0;
    flush_all = 0; flush_asid_en = 0; flush_asid = '0;
  endtask

  function automatic int eff(logic [1:0] s);
    return (s == 2'd3) ? 0 : int'(s);
  endfunction

  task automatic check(string tag);
    checks++;
    if (lk_hit !== e_hit || lk_pa !== e_pa || lk_attr !== e_attr || lk_size !== e_sz) begin
      fails++;
      $display("FAIL %s: got hit=%0b pa=%h attr=%h size=%0d, expected hit=%0b pa=%h attr=%h size=%0d",
               tag, lk_hit, lk_pa, lk_attr, lk_size, e_hit, e_pa, e_attr, e_sz);
    end
  endtask

  // one clock: model the search on old state, then the writes, then compare
  task automatic step(string tag);
    if (lk_valid) begin
      int best = -1;
      int bsz = -1;
      for (int i = 0; i < ENT; i++) begin
        int sh = 9 * eff(m_sz[i]);
        if (m_v[i] && ((m_vpn[i] >> sh) == (lk_va[47:12] >> sh)) &&
            (m_g[i] || m_asid[i] == lk_asid) && eff(m_sz[i]) > bsz) begin
          best = i; bsz = eff(m_sz[i]);
        end
      end
      if (best < 0) begin
        e_hit = 0; e_pa = 0; e_attr = 0; e_sz = 0;
      end else begin
        longint unsigned mask = (64'd1 << (12 + 9 * bsz)) - 1;
        longint unsigned full = {24'd0, m_pfn[best], 12'd0};
        e_hit = 1;
        e_pa = 40'((full & ~mask) | (64'(lk_va) & mask));
        e_attr = m_attr[best];
        e_sz = m_sz[best];
      end
    end
    for (int i = 0; i < ENT; i++) begin
      if (flush_all) m_v[i] = 0;
      else if (flush_asid_en && !m_g[i] && m_asid[i] == flush_asid) m_v[i] = 0;
    end
    if (fill_valid && !flush_all && !flush_asid_en) begin
      int vi = -1;
      for (int i = ENT - 1; i >= 0; i--) if (!m_v[i]) vi = i;
      if (vi < 0) vi = m_ptr;
      m_v[vi] = 1; m_vpn[vi] = fill_vpn; m_asid[vi] = fill_asid; m_g[vi] = fill_global;
      m_sz[vi] = fill_size; m_pfn[vi] = fill_pfn; m_attr[vi] = fill_attr;
    end
    m_ptr = (m_ptr + 1) % ENT;
    @(posedge clk);
    @(negedge clk);
    check(tag);
    idle_inputs();
  endtask

  task automatic set_fill(logic [35:0] vpn, logic [15:0] asid, bit g, logic [1:0] sz,
                          logic [27:0] pfn, logic [7:0] attr);
    fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_global = g;
    fill_size = sz; fill_pfn = pfn; fill_attr = attr;
  endtask

  task automatic set_look(logic [35:0] vpn, logic [11:0] off, logic [15:0] asid);
    lk_valid = 1; lk_va = {vpn, off}; lk_asid = asid;
  endtask

  task automatic fill(logic [35:0] vpn, logic [15:0] asid, bit g, logic [1:0] sz,
                      logic [27:0] pfn, logic [7:0] attr, string tag);
    set_fill(vpn, asid, g, sz, pfn, attr);
    step(tag);
  endtask

  task automatic look(logic [35:0] vpn, logic [11:0] off, logic [15:0] asid, string tag);
    set_look(vpn, off, asid);
    step(tag);
  endtask

  localparam logic [35:0] A = 36'h1_2345_6789;
  localparam logic [35:0] B = 36'h7_0000_0040;
  localparam logic [35:0] C = 36'h3_3333_3200;
  localparam logic [35:0] D = 36'h5_5554_0000;
  localparam logic [35:0] E = 36'hA_BCDE_F123;
  localparam logic [35:0] F = 36'h0_0F0F_0F0F;

  initial begin
    for (int i = 0; i < ENT; i++) m_v[i] = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R13 reset outputs");
    rst_n = 1;

    step("R13 idle after reset");
    look(A, 12'h123, 16'd5, "R1 miss on empty array");
    fill(A, 16'd5, 0, 2'd0, 28'hABC_DEF1, 8'h11, "R8 first fill");
    look(A, 12'h456, 16'd5, "R1 R7 4KB hit");
    step("R1 hold after lookup");
    look(A ^ 36'd1, 12'h0, 16'd5, "R2 low bit mismatch");
    look(A ^ (36'd1 << 35), 12'h0, 16'd5, "R2 high bit mismatch");
    look(A, 12'h0, 16'd6, "R4 asid mismatch");

    fill(B, 16'd1, 1, 2'd0, 28'h000_0B0B, 8'h22, "R8 global fill");
    look(B, 12'hFFF, 16'd9, "R5 global any asid");
    look(B, 12'h001, 16'd1, "R5 global own asid");

    fill(C, 16'd5, 0, 2'd1, 28'h123_4567, 8'h33, "R3 2MB fill");
    look(C | 36'h1FF, 12'hABC, 16'd5, "R3 R7 2MB low bits ignored");
    look(C ^ 36'h200, 12'h0, 16'd5, "R3 2MB bit 9 compared");

    fill(D, 16'd5, 0, 2'd2, 28'hFED_CBA9, 8'h44, "R3 1GB fill");
    look(D | 36'h3FFFF, 12'h777, 16'd5, "R3 R7 1GB low bits ignored");
    look(D ^ 36'h40000, 12'h0, 16'd5, "R3 1GB bit 18 compared");

    fill(E, 16'd5, 0, 2'd0, 28'h000_0001, 8'h51, "R6 overlap 4KB");
    look(E, 12'h010, 16'd5, "R6 only 4KB yet");
    fill(E, 16'd5, 0, 2'd1, 28'h000_0002, 8'h52, "R6 overlap 2MB");
    look(E, 12'h010, 16'd5, "R6 2MB beats 4KB");
    fill(E & ~36'h3FFFF, 16'd5, 0, 2'd2, 28'hC00_0003, 8'h53, "R6 overlap 1GB");
    look(E, 12'h010, 16'd5, "R6 1GB beats smaller");
    fill(F, 16'd7, 0, 2'd0, 28'h000_0010, 8'h61, "R6 dup one");
    fill(F, 16'd7, 0, 2'd0, 28'h000_0011, 8'h62, "R6 dup two");
    look(F, 12'h0, 16'd7, "R6 lowest index wins tie");

    // fill and lookup in the same cycle
    set_fill(36'h9_9999_9999, 16'd3, 0, 2'd0, 28'h999_9999, 8'h71);
    set_look(36'h9_9999_9999, 12'h5, 16'd3);
    step("R10 lookup sees old contents");
    look(36'h9_9999_9999, 12'h5, 16'd3, "R10 fill visible next cycle");

    // flush by identifier together with a fill
    flush_asid_en = 1; flush_asid = 16'd5;
    set_fill(36'h4_4444_4444, 16'd8, 0, 2'd0, 28'h444_4444, 8'h81);
    set_look(A, 12'h0, 16'd5);
    step("R12 lookup during flush sees old");
    look(A, 12'h0, 16'd5, "R12 asid entries removed");
    look(B, 12'h0, 16'd5, "R12 global survives");
    look(F, 12'h0, 16'd7, "R12 other asid survives");
    look(36'h4_4444_4444, 12'h0, 16'd8, "R12 fill dropped");

    // fill to capacity, then replacement
    for (int k = 0; k < 80; k++) begin
      bit full = 1;
      for (int i = 0; i < ENT; i++) if (!m_v[i]) full = 0;
      if (full) break;
      fill(36'h0_1000_0000 + 36'(k), 16'd2, 0, 2'd0, 28'(k), 8'(k), "R8 fill free slot");
    end
    look(36'h0_1000_0000, 12'h0, 16'd2, "R8 filled entry hits");
    for (int r = 0; r < 4; r++) begin
      logic [35:0] old = m_vpn[m_ptr];
      logic [15:0] oa = m_asid[m_ptr];
      fill(36'h8_0000_0000 + 36'(r), 16'd2, 0, 2'd0, 28'h800_0000 + 28'(r), 8'hE0, "R9 replace");
      look(old, 12'h0, oa, "R9 evicted entry");
      look(36'h8_0000_0000 + 36'(r), 12'h0, 16'd2, "R9 new entry hits");
      step("R9 idle");
    end

    // flush all together with a lookup and a fill
    flush_all = 1;
    set_look(36'h8_0000_0000, 12'h0, 16'd2);
    set_fill(36'h6_6666_6666, 16'd2, 0, 2'd0, 28'h666_6666, 8'h91);
    step("R11 lookup during flush sees old");
    look(36'h8_0000_0000, 12'h0, 16'd2, "R11 flushed entry misses");
    look(B, 12'h0, 16'd2, "R11 global flushed");
    look(36'h6_6666_6666, 12'h0, 16'd2, "R11 fill dropped");
    fill(36'h2_2222_2222, 16'd4, 0, 2'd3, 28'h222_2222, 8'hA1, "R3 code 3 fill");
    look(36'h2_2222_2222, 12'hFED, 16'd4, "R3 code 3 full compare");
    look(36'h2_2222_2223, 12'h0, 16'd4, "R3 code 3 low bit compared");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule